// File: doc/BRIEF.md
# Prefixed fetch and stack sequencer

This block is the front end of a small byte-oriented processor core. Each instruction starts with a pulse on `step`. The block then reads the opcode byte at the program counter from a synchronous byte-wide memory. One escape byte, 0xCB, makes it read a second byte that is decoded from an alternate table. It also runs the stack sequences that some opcodes need. These are a byte push, a register-pair push, a register-pair pop, and a return that is taken only when the zero flag is clear. Other instructions are treated as plain cycle charges, because their execution belongs to a different unit.

The block keeps a 16-bit program counter, a 16-bit stack pointer and a 32-bit running cycle total. Every instruction adds its cycle charge to that total. `busy` is high from the opcode fetch until the last memory access of the instruction. `done` is high for one cycle after that, and the cycle total is updated at the end of that cycle.

The memory has a one-cycle read latency. A read strobe in one cycle returns its data in the next cycle.

Top module: `stk_fetch_seq`

## Requirements
- R1: An opcode fetch reads memory at the program counter and then increments the counter. The counter wraps from 0xFFFF to 0x0000.
- R2: A first byte of 0xCB causes a second read at the incremented counter, and the counter increments again. The second byte becomes `opcode` with `prefixed` set to 1, and the instruction costs 8 cycles.
- R3: A second byte of 0xCB does not start another escape. It is reported as opcode 0xCB from the alternate table, and the counter advances by exactly 2.
- R4: Opcode 0xD3 (byte push) decrements SP by one and then writes `push_data[7:0]` at the new SP. It costs 8 cycles.
- R5: Opcode 0xC5 (pair push) first writes `push_data[15:8]` at SP-1 and then writes `push_data[7:0]` at SP-2. SP ends 2 lower, and the instruction costs 16 cycles.
- R6: Opcode 0xC1 (pair pop) reads the low byte at SP and the high byte at SP+1. It presents them on `pop_data`, leaves SP 2 higher, and costs 12 cycles.
- R7: Opcode 0xC0 (return if not zero) with `zero_flag` at 1 makes no memory access after the fetch. SP does not change, the counter only steps past the opcode, and the cost is 8 cycles.
- R8: Opcode 0xC0 with `zero_flag` at 0 pops a word in the same byte order as R6 and loads it into the program counter. SP ends 2 higher, and the cost is 8 plus an extra 12, for 20 cycles.
- R9: Any other opcode from the main table is a no-op. It makes no write, leaves SP unchanged and costs 4 cycles.
- R10: After reset `ticks` is 0. Each instruction adds its cost exactly once, in the cycle after `done`, and the total wraps at 32 bits. At all other times `ticks` holds.
- R11: After reset the counter is 0x0000, SP is 0xFFFE, and `busy` and `done` are 0. `busy` stays high for every cycle from the fetch to the last stack access. The count is 2 for a no-op, 3 for an escaped opcode, 3 for a byte push, 4 for a pair push, and 5 for a pop or a taken return. `done` then pulses for one cycle while `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step | input | 1 | Start one instruction when idle |
| zero_flag | input | 1 | Zero condition for the conditional return |
| push_data | input | 16 | Register pair or byte (low half) to push |
| mem_rdata | input | 8 | Read data, valid the cycle after `mem_rd` |
| mem_addr | output | 16 | Memory byte address |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write data |
| opcode | output | 8 | Last decoded opcode |
| prefixed | output | 1 | Last opcode came from the alternate table |
| pop_data | output | 16 | Word taken by the last pair pop |
| pc | output | 16 | Program counter |
| sp | output | 16 | Stack pointer |
| ticks | output | 32 | Running cycle total |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle end-of-instruction pulse |

## Verification
A stack pointer that is off by one shows up in the very next push or pop instruction. The write lands at the wrong address, or `pop_data` comes back with the bytes swapped or stale, and `sp` is wrong once `done` goes high. A wrong program counter appears at the next fetch address. After a return it appears immediately, because the following opcode is read from the wrong place, and `opcode` is wrong one instruction later. A wrong cost or a double charge only appears in `ticks`, and only in the cycle after `done`. For that reason the total is compared after every instruction. A state machine that takes the wrong path shows up as a wrong count of `busy` cycles or of write strobes within the same instruction.

// File: rtl/stk_seq_pkg.sv
package stk_seq_pkg;

  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;
  localparam int COST_W = 5;

  localparam logic [DATA_W-1:0] ESC_CODE  = 8'hCB;
  localparam logic [DATA_W-1:0] OP_PUSH_B = 8'hD3;
  localparam logic [DATA_W-1:0] OP_PUSH_W = 8'hC5;
  localparam logic [DATA_W-1:0] OP_POP_W  = 8'hC1;
  localparam logic [DATA_W-1:0] OP_RET_NZ = 8'hC0;

  localparam logic [COST_W-1:0] COST_NOP    = 5'd4;
  localparam logic [COST_W-1:0] COST_ESC    = 5'd8;
  localparam logic [COST_W-1:0] COST_PUSH_B = 5'd8;
  localparam logic [COST_W-1:0] COST_PUSH_W = 5'd16;
  localparam logic [COST_W-1:0] COST_POP_W  = 5'd12;
  localparam logic [COST_W-1:0] COST_RET    = 5'd8;
  localparam logic [COST_W-1:0] COST_RET_EX = 5'd12;

  typedef enum logic [3:0] {
    ST_IDLE, ST_FETCH, ST_DEC, ST_PUSH_HI, ST_PUSH_LO,
    ST_POP_LO, ST_POP_HI, ST_POP_END, ST_DONE
  } seq_state_t;

  typedef enum logic [2:0] {
    K_NOP, K_ALT, K_PUSH_B, K_PUSH_W, K_POP_W, K_RET_SKIP, K_RET_TAKE
  } op_kind_t;

endpackage

// File: rtl/stk_op_decode.sv
module stk_op_decode
  import stk_seq_pkg::*;
(
  input  logic [DATA_W-1:0] op_byte,
  input  logic              alt_table,
  input  logic              zero_flag,
  output op_kind_t          kind,
  output logic [COST_W-1:0] cost
);

  always_comb begin
    kind = K_NOP;
    cost = COST_NOP;
    if (alt_table) begin
      kind = K_ALT;
      cost = COST_ESC;
    end else begin
      case (op_byte)
        OP_PUSH_B: begin kind = K_PUSH_B; cost = COST_PUSH_B; end
        OP_PUSH_W: begin kind = K_PUSH_W; cost = COST_PUSH_W; end
        OP_POP_W:  begin kind = K_POP_W;  cost = COST_POP_W;  end
        OP_RET_NZ: begin
          if (zero_flag) begin
            kind = K_RET_SKIP;
            cost = COST_RET;
          end else begin
            kind = K_RET_TAKE;
            cost = COST_RET + COST_RET_EX;
          end
        end
        default: begin kind = K_NOP; cost = COST_NOP; end
      endcase
    end
  end

endmodule

// File: rtl/stk_sp_reg.sv
module stk_sp_reg #(
  parameter int          W        = 16,
  parameter logic [15:0] SP_RESET = 16'hFFFE
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         dec,
  output logic [W-1:0] sp,
  output logic [W-1:0] sp_minus1
);

  logic [W-1:0] sp_n;

  assign sp_minus1 = sp - {{(W-1){1'b0}}, 1'b1};

  always_comb begin
    sp_n = sp;
    if (dec)      sp_n = sp_minus1;
    else if (inc) sp_n = sp + {{(W-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          sp <= SP_RESET[W-1:0];
    else if (inc || dec) sp <= sp_n;
  end

  AST_SP_ONE_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    !(inc && dec)); // R6

  AST_SP_DEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    dec |=> sp == $past(sp) - {{(W-1){1'b0}}, 1'b1}); // R5

endmodule

// File: rtl/stk_tick_acc.sv
module stk_tick_acc #(
  parameter int TICK_W = 32,
  parameter int COST_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              add,
  input  logic [COST_W-1:0] cost,
  output logic [TICK_W-1:0] ticks
);

  logic [TICK_W-1:0] ticks_n;

  assign ticks_n = ticks + {{(TICK_W-COST_W){1'b0}}, cost};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   ticks <= '0;
    else if (add) ticks <= ticks_n;
  end

  AST_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !add |=> $stable(ticks)); // R10

endmodule

// File: rtl/stk_fetch_seq.sv
module stk_fetch_seq
  import stk_seq_pkg::*;
#(
  parameter logic [15:0] PC_RESET = 16'h0000,
  parameter logic [15:0] SP_RESET = 16'hFFFE,
  parameter int          TICK_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic              zero_flag,
  input  logic [15:0]       push_data,
  input  logic [7:0]        mem_rdata,
  output logic [15:0]       mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [7:0]        mem_wdata,
  output logic [7:0]        opcode,
  output logic              prefixed,
  output logic [15:0]       pop_data,
  output logic [15:0]       pc,
  output logic [15:0]       sp,
  output logic [TICK_W-1:0] ticks,
  output logic              busy,
  output logic              done
);

  localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

  seq_state_t        st, st_n;
  logic [ADDR_W-1:0] pc_n;
  logic              pfx_n;
  logic [DATA_W-1:0] op_n, lo_q, lo_n;
  logic [15:0]       pop_n;
  op_kind_t          kind_q, kind_n, dec_kind;
  logic [COST_W-1:0] cost_q, cost_n, dec_cost;
  logic              sp_inc, sp_dec, tick_add;
  logic [ADDR_W-1:0] sp_m1;

  stk_op_decode u_dec (
    .op_byte   (mem_rdata),
    .alt_table (prefixed),
    .zero_flag (zero_flag),
    .kind      (dec_kind),
    .cost      (dec_cost)
  );

  stk_sp_reg #(.W(ADDR_W), .SP_RESET(SP_RESET)) u_sp (
    .clk       (clk),
    .rst_n     (rst_n),
    .inc       (sp_inc),
    .dec       (sp_dec),
    .sp        (sp),
    .sp_minus1 (sp_m1)
  );

  stk_tick_acc #(.TICK_W(TICK_W), .COST_W(COST_W)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .add   (tick_add),
    .cost  (cost_q),
    .ticks (ticks)
  );

  assign busy = (st != ST_IDLE) && (st != ST_DONE);
  assign done = (st == ST_DONE);

  always_comb begin
    st_n      = st;
    pc_n      = pc;
    pfx_n     = prefixed;
    op_n      = opcode;
    kind_n    = kind_q;
    cost_n    = cost_q;
    lo_n      = lo_q;
    pop_n     = pop_data;
    mem_rd    = 1'b0;
    mem_wr    = 1'b0;
    mem_addr  = pc;
    mem_wdata = '0;
    sp_inc    = 1'b0;
    sp_dec    = 1'b0;
    tick_add  = 1'b0;
    case (st)
      ST_IDLE: begin
        if (step) begin
          st_n  = ST_FETCH;
          pfx_n = 1'b0;
        end
      end
      ST_FETCH: begin
        mem_rd   = 1'b1;
        mem_addr = pc;
        pc_n     = pc + ONE;
        st_n     = ST_DEC;
      end
      ST_DEC: begin
        if (!prefixed && mem_rdata == ESC_CODE) begin
          mem_rd   = 1'b1;
          mem_addr = pc;
          pc_n     = pc + ONE;
          pfx_n    = 1'b1;
        end else begin
          op_n   = mem_rdata;
          kind_n = dec_kind;
          cost_n = dec_cost;
          case (dec_kind)
            K_PUSH_W:            st_n = ST_PUSH_HI;
            K_PUSH_B:            st_n = ST_PUSH_LO;
            K_POP_W, K_RET_TAKE: st_n = ST_POP_LO;
            default:             st_n = ST_DONE;
          endcase
        end
      end
      ST_PUSH_HI: begin
        mem_wr    = 1'b1;
        mem_addr  = sp_m1;
        mem_wdata = push_data[15:8];
        sp_dec    = 1'b1;
        st_n      = ST_PUSH_LO;
      end
      ST_PUSH_LO: begin
        mem_wr    = 1'b1;
        mem_addr  = sp_m1;
        mem_wdata = push_data[7:0];
        sp_dec    = 1'b1;
        st_n      = ST_DONE;
      end
      ST_POP_LO: begin
        mem_rd   = 1'b1;
        mem_addr = sp;
        sp_inc   = 1'b1;
        st_n     = ST_POP_HI;
      end
      ST_POP_HI: begin
        mem_rd   = 1'b1;
        mem_addr = sp;
        sp_inc   = 1'b1;
        lo_n     = mem_rdata;
        st_n     = ST_POP_END;
      end
      ST_POP_END: begin
        if (kind_q == K_RET_TAKE) pc_n  = {mem_rdata, lo_q};
        else                      pop_n = {mem_rdata, lo_q};
        st_n = ST_DONE;
      end
      ST_DONE: begin
        tick_add = 1'b1;
        st_n     = ST_IDLE;
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      pc       <= PC_RESET;
      prefixed <= 1'b0;
      opcode   <= '0;
      kind_q   <= K_NOP;
      cost_q   <= '0;
      lo_q     <= '0;
      pop_data <= '0;
    end else begin
      st       <= st_n;
      pc       <= pc_n;
      prefixed <= pfx_n;
      opcode   <= op_n;
      kind_q   <= kind_n;
      cost_q   <= cost_n;
      lo_q     <= lo_n;
      pop_data <= pop_n;
    end
  end

  AST_FETCH_AT_PC: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_FETCH) |-> (mem_rd && mem_addr == pc)); // R1

  AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_FETCH) |=> (pc == $past(pc) + ONE)); // R1

  AST_WR_BELOW_SP: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> (mem_addr == sp - ONE && !mem_rd)); // R4

  AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done)); // R11

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R11

  AST_SKIP_NO_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (done && kind_q == K_RET_SKIP) |-> $stable(sp)); // R7

endmodule

// File: tb/sim_stk_fetch_seq.sv
module sim_stk_fetch_seq;

  logic        clk;
  logic        rst_n;
  logic        step;
  logic        zero_flag;
  logic [15:0] push_data;
  logic [7:0]  mem_rdata;
  logic [15:0] mem_addr;
  logic        mem_rd, mem_wr;
  logic [7:0]  mem_wdata;
  logic [7:0]  opcode;
  logic        prefixed;
  logic [15:0] pop_data, pc, sp;
  logic [31:0] ticks;
  logic        busy, done;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;
  logic [31:0] exp_ticks = 0;
  logic [7:0]  ram [0:255];

  stk_fetch_seq u0 (
    .clk(clk), .rst_n(rst_n), .step(step), .zero_flag(zero_flag),
    .push_data(push_data), .mem_rdata(mem_rdata), .mem_addr(mem_addr),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata),
    .opcode(opcode), .prefixed(prefixed), .pop_data(pop_data),
    .pc(pc), .sp(sp), .ticks(ticks), .busy(busy), .done(done)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(posedge clk) begin
    if (mem_wr) ram[mem_addr[7:0]] <= mem_wdata;
    if (mem_rd) mem_rdata <= ram[mem_addr[7:0]];
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 20000) begin
      n_checks = n_checks + 1;
      n_fail   = n_fail + 1;
      $display("FAIL watchdog: act=%0d exp<%0d cycles", cyc, 20000);
      $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks = n_checks + 1;
    if (act !== exp) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: act=0x%0h exp=0x%0h", req, act, exp);
    end
  endtask

  // Runs one instruction; returns busy-cycle and write-strobe counts.
  task automatic exec(input logic z, input logic [15:0] pd,
                      output int nbusy, output int nwr);
    nbusy = 0;
    nwr   = 0;
    @(negedge clk);
    zero_flag = z;
    push_data = pd;
    step      = 1'b1;
    @(negedge clk);
    step = 1'b0;
    for (int i = 0; i < 40; i++) begin
      if (done) break;
      if (busy) nbusy = nbusy + 1;
      if (mem_wr) nwr = nwr + 1;
      @(negedge clk);
    end
    @(negedge clk);
  endtask

  task automatic t_nop;
    int b, w;
    exec(1'b0, 16'h0000, b, w);
    exp_ticks = exp_ticks + 4;
    chk("R9 opcode", {24'd0, opcode}, 32'h00);
    chk("R9 no write", w, 0);
    chk("R9 sp", {16'd0, sp}, 32'hFFFE);
    chk("R1 pc", {16'd0, pc}, 32'h0001);
    chk("R11 busy cycles nop", b, 2);
    chk("R10 ticks", ticks, exp_ticks);
  endtask

  task automatic t_prefix;
    int b, w;
    exec(1'b0, 16'h0000, b, w);
    exp_ticks = exp_ticks + 8;
    chk("R2 opcode", {24'd0, opcode}, 32'h11);
    chk("R2 prefixed", {31'd0, prefixed}, 32'd1);
    chk("R2 pc", {16'd0, pc}, 32'h0003);
    chk("R11 busy cycles alt", b, 3);
    chk("R10 ticks", ticks, exp_ticks);
  endtask

  task automatic t_prefix_cb;
    int b, w;
    exec(1'b0, 16'h0000, b, w);
    exp_ticks = exp_ticks + 8;
    chk("R3 opcode", {24'd0, opcode}, 32'hCB);
    chk("R3 prefixed", {31'd0, prefixed}, 32'd1);
    chk("R3 pc", {16'd0, pc}, 32'h0005);
    chk("R3 ticks", ticks, exp_ticks);
  endtask

  task automatic t_push_byte;
    int b, w;
    exec(1'b0, 16'h12A5, b, w);
    exp_ticks = exp_ticks + 8;
    chk("R4 sp", {16'd0, sp}, 32'hFFFD);
    chk("R4 mem", {24'd0, ram[8'hFD]}, 32'hA5);
    chk("R4 writes", w, 1);
    chk("R11 busy cycles bpush", b, 3);
    chk("R4 ticks", ticks, exp_ticks);
    chk("R4 prefixed clear", {31'd0, prefixed}, 32'd0);
  endtask

  task automatic t_push_word(input logic [15:0] v, input logic [15:0] exp_pc);
    int b, w;
    exec(1'b0, v, b, w);
    exp_ticks = exp_ticks + 16;
    chk("R5 sp", {16'd0, sp}, 32'hFFFB);
    chk("R5 hi byte", {24'd0, ram[8'hFC]}, {24'd0, v[15:8]});
    chk("R5 lo byte", {24'd0, ram[8'hFB]}, {24'd0, v[7:0]});
    chk("R5 writes", w, 2);
    chk("R11 busy cycles wpush", b, 4);
    chk("R5 pc", {16'd0, pc}, {16'd0, exp_pc});
    chk("R5 ticks", ticks, exp_ticks);
  endtask

  task automatic t_pop_pair;
    int b, w;
    exec(1'b0, 16'h0000, b, w);
    exp_ticks = exp_ticks + 12;
    chk("R6 pop_data", {16'd0, pop_data}, 32'hBEEF);
    chk("R6 sp", {16'd0, sp}, 32'hFFFD);
    chk("R6 no write", w, 0);
    chk("R11 busy cycles pop", b, 5);
    chk("R6 ticks", ticks, exp_ticks);
  endtask

  task automatic t_ret_skip;
    int b, w;
    exec(1'b1, 16'h0000, b, w);
    exp_ticks = exp_ticks + 8;
    chk("R7 pc", {16'd0, pc}, 32'h0009);
    chk("R7 sp", {16'd0, sp}, 32'hFFFD);
    chk("R7 busy cycles", b, 2);
    chk("R7 ticks", ticks, exp_ticks);
  endtask

  task automatic t_ret_take;
    int b, w;
    exec(1'b0, 16'h0000, b, w);
    exp_ticks = exp_ticks + 20;
    chk("R8 pc", {16'd0, pc}, 32'hFFFF);
    chk("R8 sp", {16'd0, sp}, 32'hFFFD);
    chk("R8 pop_data kept", {16'd0, pop_data}, 32'hBEEF);
    chk("R11 busy cycles ret", b, 5);
    chk("R8 ticks", ticks, exp_ticks);
  endtask

  task automatic t_wrap;
    int b, w;
    exec(1'b0, 16'h0000, b, w);
    exp_ticks = exp_ticks + 4;
    chk("R1 wrap pc", {16'd0, pc}, 32'h0000);
    chk("R1 wrap opcode", {24'd0, opcode}, 32'h3E);
    chk("R10 ticks", ticks, exp_ticks);
    exec(1'b0, 16'h0000, b, w);
    exp_ticks = exp_ticks + 4;
    chk("R1 after wrap pc", {16'd0, pc}, 32'h0001);
    chk("R10 ticks", ticks, exp_ticks);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) ram[i] = 8'h00;
    ram[8'h00] = 8'h00;
    ram[8'h01] = 8'hCB; ram[8'h02] = 8'h11;
    ram[8'h03] = 8'hCB; ram[8'h04] = 8'hCB;
    ram[8'h05] = 8'hD3;
    ram[8'h06] = 8'hC5;
    ram[8'h07] = 8'hC1;
    ram[8'h08] = 8'hC0;
    ram[8'h09] = 8'hC5;
    ram[8'h0A] = 8'hC0;
    ram[8'hFF] = 8'h3E;
    rst_n     = 1'b0;
    step      = 1'b0;
    zero_flag = 1'b0;
    push_data = 16'h0000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 reset pc", {16'd0, pc}, 32'h0000);
    chk("R11 reset sp", {16'd0, sp}, 32'hFFFE);
    chk("R11 reset busy", {31'd0, busy}, 32'd0);
    chk("R11 reset done", {31'd0, done}, 32'd0);
    chk("R10 reset ticks", ticks, 32'd0);
    t_nop();
    t_prefix();
    t_prefix_cb();
    t_push_byte();
    t_push_word(16'hBEEF, 16'h0007);
    t_pop_pair();
    t_ret_skip();
    t_push_word(16'hFFFF, 16'h000A);
    t_ret_take();
    t_wrap();
    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule